// File: doc/BRIEF.md
# Fully Associative Address Translation Lookaside Buffer

This block turns a 32-bit virtual address into a physical address. Every stored entry is compared in parallel against the request. Before the entry array is consulted, fixed address-space rules are applied: some regions bypass translation and some are closed to user mode. Page protection is then checked against the one entry that matched. Each entry has its own page size (1 KB, 4 KB, 64 KB or 1 MB). An entry can be marked global, and a global entry matches any address-space identifier.

A request is presented for one cycle with `req_valid`. It carries the address, the access kind, the current address-space identifier and three mode bits: privileged, single-virtual and translation-enable. The result appears one cycle later on the `rsp_*` outputs. It is either a physical address with `rsp_hit` set, or a nonzero exception code. A separate write port loads one entry per cycle at a chosen index. Walking page tables in memory and cache control are left to other blocks.

Top module: `tlb_xlate`

## Requirements
- R1: Reset invalidates every entry and clears `rsp_valid`. A write with `wr_en` high replaces the entry at `wr_idx` from the next cycle on. Writing an entry with `wr_valid` 0 removes it from matching.
- R2: `wr_size` selects the page size: 0 is 1 KB, 1 is 4 KB, 2 is 64 KB, 3 is 1 MB. The stored page number is compared with address bits [31:10] only above the page offset of that size.
- R3: A non-global entry matches only when its identifier equals `cur_asid`. The identifier is ignored for entries loaded with `wr_shared` set. It is also ignored for all entries when `priv_mode` and `single_virt` are both 1.
- R4: When two or more entries match, the response carries code 0x140.
- R5: A user-mode access (`priv_mode` 0) to an entry whose protection bit 1 is clear gives code 0x0A0 for a read or fetch and 0x0C0 for a write. Access kinds are 0 read, 1 write, 2 fetch.
- R6: Among accesses that pass R5, a write to an entry whose protection bit 0 is clear gives 0x0C0. A write to an entry with its dirty bit 0 then gives 0x080.
- R7: When translation is on and no entry matches, the code is 0x040 for a read or fetch and 0x060 for a write.
- R8: Addresses 0x80000000 to 0xBFFFFFFF bypass the entries and keep only bits [28:0]. Addresses at or above 0xE0000000 bypass unchanged.
- R9: In user mode, a bypass address outside 0xE0000000 to 0xE3FFFFFF gives code 0x0E0 for a read or fetch and 0x100 for a write. Inside that window the access is allowed.
- R10: With `xlate_en` 0, any non-bypass address maps to its bits [28:0] and succeeds.
- R11: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. The response fields belong to that request.
- R12: On success `rsp_hit` is 1 and `rsp_fault` is 0. The physical address takes the entry's page frame above the page offset and the virtual address's bits below it. On any fault `rsp_hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| cur_asid | input | 8 | Current address-space identifier |
| priv_mode | input | 1 | 1 for privileged mode |
| single_virt | input | 1 | Single-virtual mode (disables the identifier check when privileged) |
| xlate_en | input | 1 | Translation enable |
| wr_en | input | 1 | Entry load strobe |
| wr_idx | input | 3 | Entry index to load |
| wr_valid | input | 1 | Valid bit of the loaded entry |
| wr_asid | input | 8 | Identifier of the loaded entry |
| wr_vpn | input | 22 | Virtual page number (address bits [31:10]) |
| wr_ppn | input | 19 | Physical frame number (address bits [28:10]) |
| wr_size | input | 2 | Page size code |
| wr_shared | input | 1 | Global entry flag |
| wr_prot | input | 2 | Protection: bit 1 user access, bit 0 write allowed |
| wr_dirty | input | 1 | Dirty bit |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_paddr | output | 32 | Physical address |
| rsp_fault | output | 12 | Exception code, 0 when no fault |

## Verification
Every cycle, the assertions check the one-cycle response timing and the link between `rsp_hit` and a zero code. They also check that the page offset passes through to the output, the user-mode address-error rule, the mapping with translation disabled, and that loaded entries land at their index. The scenarios alone exercise the per-size masking and the identifier and global rules. They also cover the multiple-match case and the order in which the protection, write-permission and dirty checks take precedence, because these depend on entry contents that only directed loads set up.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W    = 32;
    localparam int ASID_W  = 8;
    localparam int VPN_W   = 22;
    localparam int PPN_W   = 19;
    localparam int FAULT_W = 12;
    localparam int PG_LSB  = 10;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef struct packed {
        logic              valid;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [1:0]        size;
        logic              shared;
        logic [1:0]        prot;
        logic              dirty;
    } tlb_ent_t;

    localparam logic [FAULT_W-1:0] FLT_NONE    = 12'h000;
    localparam logic [FAULT_W-1:0] FLT_MISS_R  = 12'h040;
    localparam logic [FAULT_W-1:0] FLT_MISS_W  = 12'h060;
    localparam logic [FAULT_W-1:0] FLT_INIT_W  = 12'h080;
    localparam logic [FAULT_W-1:0] FLT_VIOL_R  = 12'h0A0;
    localparam logic [FAULT_W-1:0] FLT_VIOL_W  = 12'h0C0;
    localparam logic [FAULT_W-1:0] FLT_ADDR_R  = 12'h0E0;
    localparam logic [FAULT_W-1:0] FLT_ADDR_W  = 12'h100;
    localparam logic [FAULT_W-1:0] FLT_MULTI   = 12'h140;

    // Page-number bits that take part in the compare, per size code.
    function automatic logic [VPN_W-1:0] vpn_cmp_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    vpn_cmp_mask = {VPN_W{1'b1}};
            2'd1:    vpn_cmp_mask = {{(VPN_W-2){1'b1}}, 2'b0};
            2'd2:    vpn_cmp_mask = {{(VPN_W-6){1'b1}}, 6'b0};
            default: vpn_cmp_mask = {{(VPN_W-10){1'b1}}, 10'b0};
        endcase
    endfunction

    // Byte-offset bits within a page of the given size.
    function automatic logic [VA_W-1:0] page_off_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    page_off_mask = 32'h0000_03FF;
            2'd1:    page_off_mask = 32'h0000_0FFF;
            2'd2:    page_off_mask = 32'h0000_FFFF;
            default: page_off_mask = 32'h000F_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  tlb_ent_t                  wr_ent,
    output tlb_ent_t [ENTRIES-1:0]    ents
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                ents[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                ents[g] <= wr_ent;
            end
        end
    end

    AST_WR_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ents[$past(wr_idx)] == $past(wr_ent)));  // R1

endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  tlb_ent_t [ENTRIES-1:0] ents,
    input  logic [VA_W-1:0]        vaddr,
    input  logic [ASID_W-1:0]      cur_asid,
    input  logic                   asid_chk,
    output logic                   any_hit,
    output logic                   multi,
    output tlb_ent_t               hit_ent
);

    logic [ENTRIES-1:0] hit_vec;
    logic [VPN_W-1:0]   va_pn;

    assign va_pn = vaddr[VA_W-1:PG_LSB];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic pn_eq;
        logic id_ok;
        assign pn_eq = ((va_pn ^ ents[g].vpn) & vpn_cmp_mask(ents[g].size)) == '0;
        assign id_ok = ents[g].shared || !asid_chk || (ents[g].asid == cur_asid);
        assign hit_vec[g] = ents[g].valid && pn_eq && id_ok;
    end

    always_comb begin
        hit_ent = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_ent = hit_ent | ents[i];
        end
    end

    assign any_hit = |hit_vec;
    assign multi   = $countones(hit_vec) > 1;

endmodule

// File: rtl/tlb_judge.sv
module tlb_judge
    import tlb_pkg::*;
(
    input  logic [VA_W-1:0]    vaddr,
    input  logic [1:0]         kind,
    input  logic               priv_mode,
    input  logic               xlate_en,
    input  logic               any_hit,
    input  logic               multi,
    input  tlb_ent_t           hit_ent,
    output logic               ok,
    output logic [FAULT_W-1:0] fault,
    output logic [VA_W-1:0]    paddr
);

    logic is_wr, in_p12, in_p4, in_sq, bypass;
    logic [VA_W-1:0] omask;
    logic [VA_W-1:0] frame;

    assign is_wr  = (acc_e'(kind) == ACC_WRITE);
    assign in_p12 = (vaddr[31:30] == 2'b10);
    assign in_p4  = (vaddr[31:29] == 3'b111);
    assign in_sq  = (vaddr[31:26] == 6'b111000);
    assign bypass = in_p12 || in_p4;
    assign omask  = page_off_mask(hit_ent.size);
    assign frame  = {3'b000, hit_ent.ppn, {PG_LSB{1'b0}}};

    always_comb begin
        ok    = 1'b0;
        fault = FLT_NONE;
        paddr = '0;
        if (bypass) begin
            if (!priv_mode && !in_sq) begin
                fault = is_wr ? FLT_ADDR_W : FLT_ADDR_R;
            end else begin
                ok    = 1'b1;
                paddr = in_p12 ? {3'b000, vaddr[28:0]} : vaddr;
            end
        end else if (!xlate_en) begin
            ok    = 1'b1;
            paddr = {3'b000, vaddr[28:0]};
        end else if (multi) begin
            fault = FLT_MULTI;
        end else if (!any_hit) begin
            fault = is_wr ? FLT_MISS_W : FLT_MISS_R;
        end else if (!priv_mode && !hit_ent.prot[1]) begin
            fault = is_wr ? FLT_VIOL_W : FLT_VIOL_R;
        end else if (is_wr && !hit_ent.prot[0]) begin
            fault = FLT_VIOL_W;
        end else if (is_wr && !hit_ent.dirty) begin
            fault = FLT_INIT_W;
        end else begin
            ok    = 1'b1;
            paddr = (frame & ~omask) | (vaddr & omask);
        end
    end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [31:0]        req_vaddr,
    input  logic [1:0]         req_kind,
    input  logic [7:0]         cur_asid,
    input  logic               priv_mode,
    input  logic               single_virt,
    input  logic               xlate_en,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_valid,
    input  logic [7:0]         wr_asid,
    input  logic [21:0]        wr_vpn,
    input  logic [18:0]        wr_ppn,
    input  logic [1:0]         wr_size,
    input  logic               wr_shared,
    input  logic [1:0]         wr_prot,
    input  logic               wr_dirty,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [31:0]        rsp_paddr,
    output logic [11:0]        rsp_fault
);

    tlb_ent_t                 wr_ent;
    tlb_ent_t [ENTRIES-1:0]   ents;
    tlb_ent_t                 hit_ent;
    logic                     any_hit, multi, ok;
    logic [FAULT_W-1:0]       fault;
    logic [VA_W-1:0]          paddr;
    logic                     asid_chk;

    assign wr_ent = '{valid: wr_valid, asid: wr_asid, vpn: wr_vpn, ppn: wr_ppn,
                      size: wr_size, shared: wr_shared, prot: wr_prot, dirty: wr_dirty};
    assign asid_chk = !(priv_mode && single_virt);

    tlb_store #(.ENTRIES(ENTRIES)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_ent(wr_ent), .ents(ents)
    );

    tlb_cam #(.ENTRIES(ENTRIES)) u_cam (
        .ents(ents), .vaddr(req_vaddr), .cur_asid(cur_asid), .asid_chk(asid_chk),
        .any_hit(any_hit), .multi(multi), .hit_ent(hit_ent)
    );

    tlb_judge u_judge (
        .vaddr(req_vaddr), .kind(req_kind), .priv_mode(priv_mode), .xlate_en(xlate_en),
        .any_hit(any_hit), .multi(multi), .hit_ent(hit_ent),
        .ok(ok), .fault(fault), .paddr(paddr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_hit   <= ok;
                rsp_paddr <= paddr;
                rsp_fault <= fault;
            end
        end
    end

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);  // R11

    AST_RSP_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);  // R11

    AST_HIT_MEANS_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit == (rsp_fault == '0)));  // R12

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (!rsp_hit || (rsp_paddr[9:0] == $past(req_vaddr[9:0]))));  // R12

    AST_USER_ADDR_ERR: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !priv_mode && req_vaddr[31] && req_vaddr[31:29] != 3'b110
         && req_vaddr[31:26] != 6'b111000)
        |=> (rsp_fault == 12'h0E0 || rsp_fault == 12'h100));  // R9

    AST_XLATE_OFF_MAP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !xlate_en && !req_vaddr[31])
        |=> (rsp_hit && rsp_paddr == {3'b000, $past(req_vaddr[28:0])}));  // R10

endmodule

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic [1:0]  req_kind;
    logic [7:0]  cur_asid;
    logic        priv_mode, single_virt, xlate_en;
    logic        wr_en;
    logic [2:0]  wr_idx;
    logic        wr_valid;
    logic [7:0]  wr_asid;
    logic [21:0] wr_vpn;
    logic [18:0] wr_ppn;
    logic [1:0]  wr_size;
    logic        wr_shared;
    logic [1:0]  wr_prot;
    logic        wr_dirty;
    logic        rsp_valid, rsp_hit;
    logic [31:0] rsp_paddr;
    logic [11:0] rsp_fault;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    localparam logic [1:0] RD = 2'd0, WR = 2'd1, FE = 2'd2;

    always #2 clk = ~clk;

    tlb_xlate u_tlb_xlate (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .cur_asid(cur_asid), .priv_mode(priv_mode),
        .single_virt(single_virt), .xlate_en(xlate_en), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_valid(wr_valid), .wr_asid(wr_asid), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn),
        .wr_size(wr_size), .wr_shared(wr_shared), .wr_prot(wr_prot), .wr_dirty(wr_dirty),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    task automatic load(input logic [2:0] idx, input logic v, input logic [7:0] asid,
                        input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz,
                        input logic sh, input logic [1:0] pr, input logic d);
        @(negedge clk);
        wr_en = 1; wr_idx = idx; wr_valid = v; wr_asid = asid;
        wr_vpn = va[31:10]; wr_ppn = pa[28:10]; wr_size = sz;
        wr_shared = sh; wr_prot = pr; wr_dirty = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    // Issue one request and check the response one cycle later.
    task automatic look(input string tag, input logic [31:0] va, input logic [1:0] k,
                        input logic [7:0] asid, input logic pv, input logic sv, input logic en,
                        input logic [11:0] exp_fault, input logic [31:0] exp_pa);
        logic exp_hit;
        exp_hit = (exp_fault == 12'h000);
        @(negedge clk);
        req_valid = 1; req_vaddr = va; req_kind = k; cur_asid = asid;
        priv_mode = pv; single_virt = sv; xlate_en = en;
        @(negedge clk);
        req_valid = 0;
        n_tests++;
        if (!rsp_valid || rsp_hit !== exp_hit || rsp_fault !== exp_fault ||
            (exp_hit && rsp_paddr !== exp_pa)) begin
            n_fail++;
            $display("FAIL %s va=%h: got v=%b hit=%b code=%h pa=%h, exp hit=%b code=%h pa=%h",
                     tag, va, rsp_valid, rsp_hit, rsp_fault, rsp_paddr,
                     exp_hit, exp_fault, exp_pa);
        end
    endtask

    task automatic t_reset;
        n_tests++;
        if (rsp_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset rsp_valid: got %b exp 0", rsp_valid);
        end
        look("R1 empty after reset", 32'h0001_0ABC, RD, 8'd5, 0, 0, 1, 12'h040, 0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        n_tests++;
        if (rsp_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 idle rsp_valid: got %b exp 0", rsp_valid);
        end
    endtask

    task automatic t_basic;
        // entry 0: 4 KB at 0x00010000, frame 0x01230000 (low frame bits set to test masking)
        load(3'd0, 1, 8'd5, 32'h0001_0000, 32'h0123_0C00, 2'd1, 0, 2'b11, 1);
        look("R12 4K hit", 32'h0001_0ABC, RD, 8'd5, 0, 0, 1, 12'h000, 32'h0123_0ABC);
        look("R3 asid mismatch", 32'h0001_0ABC, RD, 8'd6, 0, 0, 1, 12'h040, 0);
        look("R7 write miss", 32'h0001_0ABC, WR, 8'd6, 0, 0, 1, 12'h060, 0);
        look("R7 fetch miss", 32'h0000_4000, FE, 8'd5, 0, 0, 1, 12'h040, 0);
        look("R3 priv single-virt ignores asid", 32'h0001_0ABC, RD, 8'd6, 1, 1, 1,
             12'h000, 32'h0123_0ABC);
        look("R3 priv alone checks asid", 32'h0001_0ABC, RD, 8'd6, 1, 0, 1, 12'h040, 0);
    endtask

    task automatic t_sizes;
        // entry 1: 1 MB global at 0x00500000, user read only, clean
        load(3'd1, 1, 8'd9, 32'h0050_0000, 32'h0A00_0000, 2'd3, 1, 2'b10, 0);
        look("R2 R3 1M global hit", 32'h005A_BCDE, RD, 8'd3, 0, 0, 1, 12'h000, 32'h0A0A_BCDE);
        look("R6 write not allowed", 32'h005A_BCDE, WR, 8'd3, 0, 0, 1, 12'h0C0, 0);
        // entry 2: 1 KB at 0x00600000, privileged only, dirty
        load(3'd2, 1, 8'd1, 32'h0060_0000, 32'h0000_2400, 2'd0, 0, 2'b00, 1);
        look("R5 user fetch viol", 32'h0060_0010, FE, 8'd1, 0, 0, 1, 12'h0A0, 0);
        look("R5 user write viol", 32'h0060_0010, WR, 8'd1, 0, 0, 1, 12'h0C0, 0);
        look("R2 1K priv hit", 32'h0060_0010, RD, 8'd1, 1, 0, 1, 12'h000, 32'h0000_2410);
        look("R6 priv write prot0 clear", 32'h0060_0010, WR, 8'd1, 1, 0, 1, 12'h0C0, 0);
        look("R2 1K next page misses", 32'h0060_0400, RD, 8'd1, 1, 0, 1, 12'h040, 0);
        // entry 3: 64 KB at 0x00700000, writable, clean
        load(3'd3, 1, 8'd1, 32'h0070_0000, 32'h0034_0000, 2'd2, 0, 2'b11, 0);
        look("R2 64K hit", 32'h0070_FFFC, RD, 8'd1, 0, 0, 1, 12'h000, 32'h0034_FFFC);
        look("R6 initial write", 32'h0070_1000, WR, 8'd1, 0, 0, 1, 12'h080, 0);
    endtask

    task automatic t_multi;
        // entry 4: 1 MB global at 0, overlapping entry 0
        load(3'd4, 1, 8'd0, 32'h0000_0000, 32'h00F0_0000, 2'd3, 1, 2'b11, 1);
        look("R4 multiple hit", 32'h0001_0ABC, RD, 8'd5, 0, 0, 1, 12'h140, 0);
        look("R3 global only", 32'h0001_0ABC, RD, 8'd6, 0, 0, 1, 12'h000, 32'h00F1_0ABC);
        load(3'd4, 0, 8'd0, 32'h0000_0000, 32'h00F0_0000, 2'd3, 1, 2'b11, 1);
        look("R1 invalidated entry", 32'h0001_0ABC, RD, 8'd5, 0, 0, 1, 12'h000, 32'h0123_0ABC);
    endtask

    task automatic t_bypass;
        look("R8 P1 low bits", 32'h9234_5678, RD, 8'd0, 1, 0, 1, 12'h000, 32'h1234_5678);
        look("R8 P2 low bits", 32'hA000_0004, WR, 8'd0, 1, 0, 1, 12'h000, 32'h0000_0004);
        look("R8 top unchanged", 32'hF000_0010, FE, 8'd0, 1, 0, 1, 12'h000, 32'hF000_0010);
        look("R9 user window ok", 32'hE100_0000, WR, 8'd0, 0, 0, 1, 12'h000, 32'hE100_0000);
        look("R9 user read err", 32'h8000_0000, RD, 8'd0, 0, 0, 1, 12'h0E0, 0);
        look("R9 user fetch err", 32'hBFFF_FFFC, FE, 8'd0, 0, 0, 0, 12'h0E0, 0);
        look("R9 user write err", 32'hE400_0000, WR, 8'd0, 0, 0, 1, 12'h100, 0);
    endtask

    task automatic t_off;
        look("R10 off low", 32'h7FFF_FFFF, RD, 8'd0, 0, 0, 0, 12'h000, 32'h1FFF_FFFF);
        look("R10 off C0 region", 32'hC123_4567, WR, 8'd0, 1, 0, 0, 12'h000, 32'h0123_4567);
    endtask

    initial begin
        rst = 1; req_valid = 0; req_vaddr = 0; req_kind = 0; cur_asid = 0;
        priv_mode = 0; single_virt = 0; xlate_en = 0; wr_en = 0; wr_idx = 0;
        wr_valid = 0; wr_asid = 0; wr_vpn = 0; wr_ppn = 0; wr_size = 0;
        wr_shared = 0; wr_prot = 0; wr_dirty = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_idle();
        t_basic();
        t_sizes();
        t_multi();
        t_bypass();
        t_off();
        t_idle();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule